// File: doc/BRIEF.md
# Eight-Bit Accumulator Execution Core

This block is a small multi-cycle processor that executes a narrow set of one- and two-byte instructions. It fetches from a 64 KiB address space. The lower half is program ROM, filled through a load port while reset is held. The upper half is working RAM. The core keeps six general 8-bit registers plus an accumulator and a flag byte. It can add into the accumulator, store the accumulator to memory through the H/L pair, write the accumulator to an output port, and stop.

Every instruction occupies a fixed number of clock cycles. The count depends on the instruction and on where its operand comes from. When an instruction retires, the core raises a one-cycle `done` pulse and reports that cost, the new program counter, the accumulator and the flags. The core is used by loading a program image during reset, releasing reset, and watching the retire pulses and the output port until `halted` rises.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, every edge clears PC, all registers and flags to zero, and drives `done`, `io_stb`, `halted` and `illegal` low.
- R2: An opcode of the form 00rrr110 followed by one byte loads that byte into register rrr. The register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111. The instruction costs 7 cycles, advances PC by 2 and leaves the flags unchanged.
- R3: An opcode 10000rrr with rrr not equal to 110 adds register rrr to A and writes the sum modulo 256 to A. It costs 4 cycles and advances PC by 1. Code 111 adds A to itself.
- R4: An add writes F as follows: bit7 is the sign of the result, bit6 is a zero result, bit4 is the carry out of bit 3, bit2 is signed overflow, bit1 (subtract) is 0, bit0 is the carry out of bit 7. Bits 5 and 3 are 0.
- R5: Opcode 0xC6 followed by one byte adds that byte to A (7 cycles, PC+2). Opcode 0x86 adds the memory byte at address {H,L} to A (7 cycles, PC+1). Both set flags as in R4.
- R6: Opcode 0xD3 followed by byte n costs 11 cycles and advances PC by 2. In its retire cycle it drives a one-cycle `io_stb` with `io_addr` = n and `io_data` = A. `io_stb` never rises outside such a retire cycle.
- R7: Opcode 0x76 costs 4 cycles, advances PC by 1 and retires with a `done` pulse. After that `halted` stays high, PC stays frozen and no further `done` occurs until reset.
- R8: Opcode 0x77 (7 cycles, PC+1) writes A to address {H,L}. Addresses 0x8000 to 0xFFFF reach RAM at offset address-0x8000, taken modulo the RAM depth. A write below 0x8000 changes nothing and does not raise `illegal`.
- R9: An opcode outside this set raises `illegal` and `halted`, produces no `done` pulse, and leaves PC at the address of that opcode.
- R10: `done` is high for exactly one cycle per instruction. `cost` equals the number of clock edges from the start of that instruction to its retire edge, which is also the spacing between consecutive `done` pulses.
- R11: The load port writes ROM byte `load_addr` only while `rst_n` is low. When `rst_n` is high it has no effect.
- R12: The program 3E 08 06 04 80 D3 00 76 retires with PC 0x0002, 0x0004, 0x0005, 0x0007 and 0x0008. It ends with A = 0x0C, writes 0x0C to port 0, and then halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; ROM loading is allowed while low |
| load_we | input | 1 | ROM load write enable |
| load_addr | input | ROM_AW (8) | ROM byte address for loading |
| load_data | input | 8 | ROM byte to load |
| io_stb | output | 1 | One-cycle output port write strobe |
| io_addr | output | 8 | Output port address |
| io_data | output | 8 | Output port data |
| done | output | 1 | One-cycle pulse when an instruction retires |
| cost | output | 4 | Cycle cost of the instruction that retired |
| pc | output | 16 | Program counter |
| acc | output | 8 | Accumulator A |
| flags | output | 8 | Flag register F |
| halted | output | 1 | Core has stopped fetching |
| illegal | output | 1 | An unsupported opcode was met |

## Verification
The output-port strobe and the retire pulse are two separate functions that fall in the same cycle whenever an OUT instruction finishes. The bench provokes this with OUT in two different programs. Its monitor treats each retire as one scoreboard item, compares the strobe, port address and port data in the same sampled cycle as the PC, accumulator, flags and cost, and counts any strobe seen without a retire as a miscompare. The same monitor also measures the edge spacing between retires against each instruction's expected cost.

// File: rtl/acc8_pkg.sv
// Package acc8_pkg
// Shared opcode constants, decode record, cycle costs and flag bit
// positions for the eight-bit accumulator core.
package acc8_pkg;
    localparam int COST_W = 4;

    localparam logic [COST_W-1:0] COST_SHORT = 4'd4;
    localparam logic [COST_W-1:0] COST_MID   = 4'd7;
    localparam logic [COST_W-1:0] COST_OUT   = 4'd11;

    localparam logic [7:0] OPC_HALT  = 8'h76;
    localparam logic [7:0] OPC_STORE = 8'h77;
    localparam logic [7:0] OPC_ADDI  = 8'hC6;
    localparam logic [7:0] OPC_OUT   = 8'hD3;

    localparam logic [2:0] RSEL_H   = 3'b100;
    localparam logic [2:0] RSEL_L   = 3'b101;
    localparam logic [2:0] RSEL_MEM = 3'b110;
    localparam logic [2:0] RSEL_A   = 3'b111;

    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_H = 4;
    localparam int FB_V = 2;
    localparam int FB_N = 1;
    localparam int FB_C = 0;

    typedef enum logic [2:0] {K_LDI, K_ADD, K_STORE, K_OUT, K_HALT, K_BAD} kind_e;
    typedef enum logic [1:0] {S_REG, S_IMM, S_MEM} src_e;

    typedef struct packed {
        kind_e             kind;
        src_e              src;
        logic              two_byte;
        logic [COST_W-1:0] cost;
        logic [2:0]        rsel;
    } dec_t;
endpackage

// File: rtl/acc8_decode.sv
// Module acc8_decode
// Combinational decode table. It maps an opcode to its operation kind,
// its operand source, its length and its fixed cycle cost.
// Assumes: the opcode is stable for the whole instruction (it is latched).
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    // Table lookup; any code not matched falls through as unsupported.
    always_comb begin
        dec = '{kind: K_BAD, src: S_REG, two_byte: 1'b0, cost: COST_SHORT, rsel: opcode[2:0]};
        if (opcode == OPC_HALT) begin
            dec.kind = K_HALT;
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b110 && opcode[5:3] != RSEL_MEM) begin
            dec.kind     = K_LDI;
            dec.src      = S_IMM;
            dec.two_byte = 1'b1;
            dec.cost     = COST_MID;
            dec.rsel     = opcode[5:3];
        end else if (opcode == OPC_STORE) begin
            dec.kind = K_STORE;
            dec.cost = COST_MID;
        end else if (opcode[7:3] == 5'b10000) begin
            dec.kind = K_ADD;
            if (opcode[2:0] == RSEL_MEM) begin
                dec.src  = S_MEM;
                dec.cost = COST_MID;
            end
        end else if (opcode == OPC_ADDI) begin
            dec.kind     = K_ADD;
            dec.src      = S_IMM;
            dec.two_byte = 1'b1;
            dec.cost     = COST_MID;
        end else if (opcode == OPC_OUT) begin
            dec.kind     = K_OUT;
            dec.src      = S_IMM;
            dec.two_byte = 1'b1;
            dec.cost     = COST_OUT;
        end
    end
endmodule

// File: rtl/acc8_alu.sv
// Module acc8_alu
// Eight-bit adder with full flag generation, packed into the flag byte.
// Assumes: only addition is needed; the subtract flag is always cleared.
module acc8_alu
    import acc8_pkg::*;
(
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] sum,
    output logic [7:0] flags
);
    logic [8:0] wide;
    logic [4:0] nib;

    // Full and low-nibble sums for the carry and half-carry.
    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        sum  = wide[7:0];
    end

    // Flag byte assembly; the unused bits stay zero.
    always_comb begin
        flags       = '0;
        flags[FB_S] = wide[7];
        flags[FB_Z] = (wide[7:0] == 8'h00);
        flags[FB_H] = nib[4];
        flags[FB_V] = (a[7] == b[7]) && (wide[7] != a[7]);
        flags[FB_N] = 1'b0;
        flags[FB_C] = wide[8];
    end
endmodule

// File: rtl/acc8_mem.sv
// Module acc8_mem
// Memory map: ROM in the lower half, RAM in the upper half, both aliased
// inside their halves by the implemented depth. ROM is written only by
// the loader while it is enabled; core writes to the ROM half are dropped.
// Assumes: reads are combinational; writes land on the clock edge.
module acc8_mem #(
    parameter int ROM_AW = 8,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              load_en,
    input  logic              load_we,
    input  logic [ROM_AW-1:0] load_addr,
    input  logic [7:0]        load_data,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       rd_addr,
    output logic [7:0]        rd_data
);
    localparam int ROM_N = 1 << ROM_AW;
    localparam int RAM_N = 1 << RAM_AW;

    logic [7:0] rom [0:ROM_N-1];
    logic [7:0] ram [0:RAM_N-1];
    logic       unused_addr_bits;

    assign unused_addr_bits = ^{rd_addr, wr_addr};

    // Loader path into ROM, open only while enabled.
    always_ff @(posedge clk) begin
        if (load_en && load_we) begin
            rom[load_addr] <= load_data;
        end
    end

    // Core store path; only the upper half reaches storage.
    always_ff @(posedge clk) begin
        if (wr_en && wr_addr[15]) begin
            ram[wr_addr[RAM_AW-1:0]] <= wr_data;
        end
    end

    // Region select on the top address bit.
    always_comb begin
        rd_data = rd_addr[15] ? ram[rd_addr[RAM_AW-1:0]] : rom[rd_addr[ROM_AW-1:0]];
    end

    assert_rom_store_dropped_R8: assert property (@(posedge clk) disable iff (load_en)
        (wr_en && !wr_addr[15]) |=>
            (rom[$past(wr_addr[ROM_AW-1:0])] == $past(rom[wr_addr[ROM_AW-1:0]])));

    assert_load_blocked_R11: assert property (@(posedge clk) disable iff (load_en)
        load_we |=> (rom[$past(load_addr)] == $past(rom[load_addr])));
endmodule

// File: rtl/acc8_core.sv
// Module acc8_core
// Top of the accumulator core. A step counter walks each instruction:
// step 0 latches the opcode, step 1 latches the operand byte (immediate
// or memory at {H,L}) or flags an unsupported opcode, and the step equal
// to cost-1 retires the instruction. The remaining steps are padding that
// fixes the cycle cost.
// Assumes: every cost is at least 4, so retire never meets steps 0 or 1.
module acc8_core
    import acc8_pkg::*;
#(
    parameter int ROM_AW = 8,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [ROM_AW-1:0] load_addr,
    input  logic [7:0]        load_data,
    output logic              io_stb,
    output logic [7:0]        io_addr,
    output logic [7:0]        io_data,
    output logic              done,
    output logic [COST_W-1:0] cost,
    output logic [15:0]       pc,
    output logic [7:0]        acc,
    output logic [7:0]        flags,
    output logic              halted,
    output logic              illegal
);
    localparam logic [COST_W-1:0] STEP_FETCH = '0;
    localparam logic [COST_W-1:0] STEP_OPND  = 1;
    localparam logic [COST_W-1:0] STEP_ONE   = 1;

    logic [COST_W-1:0] step;
    logic [7:0]        ir;
    logic [7:0]        opnd;
    logic [15:0]       pc_q;
    logic [7:0]        gpr [0:7];
    logic [7:0]        f_q;
    logic              halt_q;
    logic              bad_q;
    logic              done_q;
    logic [COST_W-1:0] cost_q;
    logic              stb_q;
    logic [7:0]        ioa_q;
    logic [7:0]        iod_q;

    dec_t              d;
    logic              last_step;
    logic [15:0]       hl;
    logic [15:0]       mem_raddr;
    logic [7:0]        mem_rdata;
    logic              mem_we;
    logic [7:0]        alu_b;
    logic [7:0]        alu_sum;
    logic [7:0]        alu_flags;

    acc8_decode u_dec (
        .opcode (ir),
        .dec    (d)
    );

    acc8_alu u_alu (
        .a     (gpr[RSEL_A]),
        .b     (alu_b),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    acc8_mem #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_mem (
        .clk       (clk),
        .load_en   (!rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .wr_en     (mem_we),
        .wr_addr   (hl),
        .wr_data   (gpr[RSEL_A]),
        .rd_addr   (mem_raddr),
        .rd_data   (mem_rdata)
    );

    // Pair view, retire detection, memory address and store enable.
    always_comb begin
        hl        = {gpr[RSEL_H], gpr[RSEL_L]};
        last_step = (step != STEP_FETCH) && (step == d.cost - STEP_ONE);
        if (step == STEP_FETCH) begin
            mem_raddr = pc_q;
        end else if (d.src == S_MEM) begin
            mem_raddr = hl;
        end else begin
            mem_raddr = pc_q + 16'd1;
        end
        mem_we = !halt_q && last_step && (d.kind == K_STORE);
        alu_b  = (d.src == S_REG) ? gpr[d.rsel] : opnd;
    end

    // Instruction sequencer and architectural state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= STEP_FETCH;
            ir     <= '0;
            opnd   <= '0;
            pc_q   <= '0;
            f_q    <= '0;
            halt_q <= 1'b0;
            bad_q  <= 1'b0;
            done_q <= 1'b0;
            cost_q <= '0;
            stb_q  <= 1'b0;
            ioa_q  <= '0;
            iod_q  <= '0;
            for (int i = 0; i < 8; i++) begin
                gpr[i] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            stb_q  <= 1'b0;
            if (!halt_q) begin
                if (step == STEP_FETCH) begin
                    ir   <= mem_rdata;
                    step <= STEP_OPND;
                end else if (step == STEP_OPND && d.kind == K_BAD) begin
                    bad_q  <= 1'b1;
                    halt_q <= 1'b1;
                    step   <= STEP_FETCH;
                end else begin
                    if (step == STEP_OPND) begin
                        opnd <= mem_rdata;
                    end
                    if (last_step) begin
                        step   <= STEP_FETCH;
                        pc_q   <= pc_q + (d.two_byte ? 16'd2 : 16'd1);
                        done_q <= 1'b1;
                        cost_q <= d.cost;
                        case (d.kind)
                            K_LDI: gpr[d.rsel] <= opnd;
                            K_ADD: begin
                                gpr[RSEL_A] <= alu_sum;
                                f_q         <= alu_flags;
                            end
                            K_OUT: begin
                                stb_q <= 1'b1;
                                ioa_q <= opnd;
                                iod_q <= gpr[RSEL_A];
                            end
                            K_HALT: halt_q <= 1'b1;
                            default: ;
                        endcase
                    end else begin
                        step <= step + STEP_ONE;
                    end
                end
            end
        end
    end

    // Output drive from registered state.
    always_comb begin
        io_stb  = stb_q;
        io_addr = ioa_q;
        io_data = iod_q;
        done    = done_q;
        cost    = cost_q;
        pc      = pc_q;
        acc     = gpr[RSEL_A];
        flags   = f_q;
        halted  = halt_q;
        illegal = bad_q;
    end

    assert_strobe_on_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |-> done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cost_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cost == COST_SHORT || cost == COST_MID || cost == COST_OUT));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!done && $stable(pc)));

    assert_illegal_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (halted && !done));
endmodule

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
    import acc8_pkg::*;

    localparam int ROM_AW = 8;
    localparam int RAM_AW = 8;
    localparam int ROM_N  = 1 << ROM_AW;
    localparam int RAM_N  = 1 << RAM_AW;

    typedef struct {
        logic [15:0] pc;
        logic [7:0]  a;
        logic [7:0]  f;
        logic [3:0]  cost;
        logic        stb;
        logic [7:0]  ioa;
        logic [7:0]  iod;
        string       req;
    } item_t;

    item_t q[$];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_we = 1'b0;
    logic [ROM_AW-1:0] load_addr = '0;
    logic [7:0]        load_data = '0;
    logic              io_stb, done, halted, illegal;
    logic [7:0]        io_addr, io_data, acc, flags;
    logic [3:0]        cost;
    logic [15:0]       pc;

    int n_vec = 0;
    int n_bad = 0;
    int edges = 0;
    int mark  = 0;

    logic [7:0]  prog  [0:ROM_N-1];
    logic [7:0]  shram [0:RAM_N-1];
    logic [7:0]  sh    [0:7];
    logic [7:0]  shf;
    logic [15:0] shpc;
    int          plen;

    always #2 clk = ~clk;

    acc8_core #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u0 (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .io_stb(io_stb), .io_addr(io_addr), .io_data(io_data),
        .done(done), .cost(cost), .pc(pc), .acc(acc), .flags(flags),
        .halted(halted), .illegal(illegal)
    );

    task automatic note(input bit ok, input string req, input string detail);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    // Edge counter for cost spacing (R10).
    always @(posedge clk) begin
        if (rst_n) edges++;
        else edges = 0;
    end

    // Monitor: pop one expected item per retire and compare.
    always @(negedge clk) begin
        if (!rst_n) begin
            mark = 0;
        end else begin
            if (io_stb && !done)
                note(1'b0, "R6", $sformatf("strobe without retire actual stb=1 done=0 expected done=1"));
            if (done) begin
                if (q.size() == 0) begin
                    note(1'b0, "R7", $sformatf("unexpected retire actual pc=%h expected none", pc));
                end else begin
                    item_t e;
                    int    gap;
                    bit    ok;
                    e   = q.pop_front();
                    gap = edges - mark;
                    mark = edges;
                    ok  = (pc == e.pc) && (acc == e.a) && (flags == e.f) && (cost == e.cost)
                          && (gap == int'(e.cost)) && (io_stb == e.stb)
                          && (!e.stb || (io_addr == e.ioa && io_data == e.iod));
                    note(ok, e.req, $sformatf(
                        "actual pc=%h a=%h f=%h cost=%0d gap=%0d stb=%b io=%h/%h expected pc=%h a=%h f=%h cost=%0d stb=%b io=%h/%h",
                        pc, acc, flags, cost, gap, io_stb, io_addr, io_data,
                        e.pc, e.a, e.f, e.cost, e.stb, e.ioa, e.iod));
                end
            end
        end
    end

    task automatic push(input logic [3:0] c, input logic s, input logic [7:0] n, input string req);
        item_t e;
        e.pc = shpc; e.a = sh[7]; e.f = shf; e.cost = c;
        e.stb = s; e.ioa = n; e.iod = sh[7]; e.req = req;
        q.push_back(e);
    endtask

    task automatic emit(input logic [7:0] b);
        prog[plen] = b;
        plen++;
    endtask

    function automatic logic [7:0] peek(input logic [15:0] addr);
        return addr[15] ? shram[addr[RAM_AW-1:0]] : prog[addr[ROM_AW-1:0]];
    endfunction

    // Reference add from R3/R4.
    task automatic model_add(input logic [7:0] b);
        logic [8:0] w;
        logic [4:0] h;
        w = {1'b0, sh[7]} + {1'b0, b};
        h = {1'b0, sh[7][3:0]} + {1'b0, b[3:0]};
        shf = {w[7], (w[7:0] == 8'h00), 1'b0, h[4], 1'b0,
               (sh[7][7] == b[7]) && (w[7] != sh[7][7]), 1'b0, w[8]};
        sh[7] = w[7:0];
    endtask

    task automatic i_ldi(input int r, input logic [7:0] n, input string req);
        emit(8'h06 | 8'(r << 3)); emit(n);
        sh[r] = n; shpc += 2;
        push(4'd7, 1'b0, 8'h00, req);
    endtask

    task automatic i_add(input int r, input string req);
        emit(8'h80 | 8'(r));
        if (r == 6) model_add(peek({sh[4], sh[5]}));
        else model_add(sh[r]);
        shpc += 1;
        push((r == 6) ? 4'd7 : 4'd4, 1'b0, 8'h00, req);
    endtask

    task automatic i_addi(input logic [7:0] n, input string req);
        emit(8'hC6); emit(n);
        model_add(n); shpc += 2;
        push(4'd7, 1'b0, 8'h00, req);
    endtask

    task automatic i_store(input string req);
        logic [15:0] a;
        emit(8'h77);
        a = {sh[4], sh[5]};
        if (a[15]) shram[a[RAM_AW-1:0]] = sh[7];
        shpc += 1;
        push(4'd7, 1'b0, 8'h00, req);
    endtask

    task automatic i_out(input logic [7:0] n, input string req);
        emit(8'hD3); emit(n);
        shpc += 2;
        push(4'd11, 1'b1, n, req);
    endtask

    task automatic i_halt(input string req);
        emit(8'h76);
        shpc += 1;
        push(4'd4, 1'b0, 8'h00, req);
    endtask

    task automatic begin_prog();
        plen = 0; shpc = '0; shf = '0;
        for (int i = 0; i < ROM_N; i++) prog[i] = 8'h00;
        for (int i = 0; i < 8; i++) sh[i] = 8'h00;
    endtask

    task automatic run_prog(input bit want_bad, input bit poke, input string req);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < ROM_N; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = ROM_AW'(i); load_data = prog[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        repeat (2) @(negedge clk);
        note(pc == 16'h0 && acc == 8'h0 && flags == 8'h0 && !done && !io_stb && !halted && !illegal,
             "R1", $sformatf("reset state actual pc=%h a=%h f=%h done=%b stb=%b halt=%b ill=%b expected all zero",
                             pc, acc, flags, done, io_stb, halted, illegal));
        rst_n = 1'b1;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                load_we = 1'b1; load_addr = '0; load_data = 8'h00;
            end
            @(negedge clk);
            load_we = 1'b0;
        end
        for (int k = 0; k < 4000 && !halted; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        note(q.size() == 0, req, $sformatf("retires missing actual pending=%0d expected 0", q.size()));
        note(halted == 1'b1, want_bad ? "R9" : "R7", $sformatf("halted actual %b expected 1", halted));
        note(illegal == want_bad, want_bad ? "R9" : "R8", $sformatf("illegal actual %b expected %b", illegal, want_bad));
        note(pc == shpc, want_bad ? "R9" : "R7", $sformatf("final pc actual %h expected %h", pc, shpc));
        q.delete();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not finish actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < RAM_N; i++) shram[i] = 8'h00;

        // R12 sample program, also covers R2, R3, R6, R7.
        begin_prog();
        i_ldi(7, 8'h08, "R12");
        i_ldi(0, 8'h04, "R12");
        i_add(0, "R12");
        i_out(8'h00, "R12");
        i_halt("R12");
        run_prog(1'b0, 1'b0, "R12");

        // Flag corners, memory map and load-port lockout.
        begin_prog();
        i_ldi(7, 8'h7F, "R2");
        i_ldi(1, 8'h01, "R2");
        i_add(1, "R4");        // 0x80: S,H,V
        i_addi(8'h80, "R5");   // 0x00: Z,V,C
        i_ldi(2, 8'hFF, "R2");
        i_add(2, "R4");        // 0xFF: S
        i_ldi(3, 8'h01, "R2");
        i_add(3, "R4");        // 0x00: Z,H,C
        i_add(7, "R3");        // A+A
        i_ldi(4, 8'h80, "R2");
        i_ldi(5, 8'h05, "R2");
        i_ldi(7, 8'h5A, "R2");
        i_store("R8");
        i_ldi(7, 8'h00, "R2");
        i_add(6, "R8");        // reads RAM back
        i_ldi(4, 8'h00, "R2");
        i_ldi(5, 8'h00, "R2");
        i_ldi(7, 8'h99, "R2");
        i_store("R8");         // ROM write dropped
        i_ldi(7, 8'h01, "R2");
        i_add(6, "R11");       // ROM[0] unchanged by store and by load port
        i_out(8'h42, "R6");
        i_halt("R7");
        run_prog(1'b0, 1'b1, "R10");

        // Unsupported opcode.
        begin_prog();
        i_ldi(7, 8'h11, "R2");
        emit(8'hDD);
        run_prog(1'b1, 1'b0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule